// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Unit

This block joins two eight-line priority controllers, a primary and a secondary, into a single sixteen-source interrupt system. Sources 0 to 7 enter the primary and sources 8 to 15 enter the secondary. Primary line 2 carries no external source. It is fed by a cascade link that produces a short pulse whenever the secondary has a request that beats everything it currently has in service. The primary's winning request drives the processor interrupt output.

When the processor strobes acknowledge, the unit resolves the primary first. It reaches into the secondary only when the primary's winner is the cascade line. It moves the chosen line(s) from pending to in-service and returns an 8-bit vector one cycle later. The upper bits of the vector come from the base of the controller that was serviced, and the lower bits come from its line number. If no real winner exists at the moment of acknowledge, each controller falls back to its own line 7. An end-of-service strobe clears one in-service bit.

Top module: `pic_casc_ack`

## Requirements
- R1: After reset `int_o`, `vec_vld_o`, `vec_o` and `src_o` are all zero, and no request is pending or in service.
- R2: A winning request in the secondary makes primary line 2 pending by way of a one-cycle cascade pulse, so `int_o` rises with no external source 2.
- R3: `vec_vld_o` is high in exactly the cycle after each single-cycle `inta_i` strobe, and it is low otherwise.
- R4: When the primary winner is a line L other than 2, the vector is `{pri_base_i[7:3], L}` and `src_o` is L. Line L becomes in service.
- R5: When the primary winner is line 2 and the secondary has a winner S, both lines become in service, the vector is `{sec_base_i[7:3], S}` and `src_o` is S+8.
- R6: When the primary winner is line 2 but the secondary has no winner, the vector is `{sec_base_i[7:3], 3'd7}` and `src_o` is 15. Primary line 2 becomes in service and the secondary is left untouched.
- R7: When the primary has no winner at acknowledge, the vector is `{pri_base_i[7:3], 3'd7}` and `src_o` is 7, and no state changes.
- R8: Bits 2:0 of both bases have no effect on the vector.
- R9: Within a controller, a lower line number has higher priority. A pending line wins only if it outranks every in-service line. `eoi_i` with `eoi_src_i` (bit 3 selects the secondary, bits 2:0 the line) clears that in-service bit.
- R10: Requests are edge triggered. A level held high is pending once, and it must fall and rise again to be pending again.
- R11: A line whose `mask_i` bit is set (bit index equals source number) cannot win, and it does not drive `int_o`.
- R12: `int_o` follows the primary's winning state with one register of delay, including after every acknowledge and end-of-service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 16 | Source request lines; bit 2 is not used (cascade owned) |
| mask_i | input | 16 | Per-source mask, 1 blocks the source |
| pri_base_i | input | 8 | Primary vector base, bits 7:3 used |
| sec_base_i | input | 8 | Secondary vector base, bits 7:3 used |
| inta_i | input | 1 | Single-cycle acknowledge strobe |
| eoi_i | input | 1 | End-of-service strobe |
| eoi_src_i | input | 4 | Source whose in-service bit is cleared |
| int_o | output | 1 | Interrupt request to the processor |
| vec_vld_o | output | 1 | Vector valid, one cycle after acknowledge |
| vec_o | output | 8 | Acknowledge vector |
| src_o | output | 4 | Serviced source number (7 or 15 for spurious) |

## Verification
The hardest case to reach is the spurious result in the secondary. It needs primary line 2 pending while the secondary no longer has a winner. Since requests are latched on edges, the stimulus raises a secondary source, waits until the cascade has set primary line 2, and then masks that source before strobing acknowledge. The random phase reaches the same situation again by changing masks and end-of-service order in the middle of a sequence. A bench model tracks pending and in-service state, so every vector is predicted from the history of requests.

// File: rtl/pic_casc_pkg.sv
package pic_casc_pkg;
  typedef enum logic [1:0] {
    ACK_SPUR_PRI = 2'd0,
    ACK_PRI      = 2'd1,
    ACK_CASC     = 2'd2,
    ACK_SPUR_SEC = 2'd3
  } ack_kind_e;
endpackage

// File: rtl/pic_resolver.sv
module pic_resolver #(
  parameter  int unsigned LINES = 8,
  localparam int unsigned LW    = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] req_i,
  input  logic [LINES-1:0] mask_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  input  logic [LW-1:0]    eoi_line_i,
  output logic             win_o,
  output logic [LW-1:0]    win_line_o
);
  logic [LINES-1:0] last_q, irr_q, isr_q;
  logic [LINES-1:0] rise, ack_vec, eoi_vec, pend;
  logic             p_hit, s_hit;
  logic [LW-1:0]    p_idx, s_idx;

  assign rise    = req_i & ~last_q;
  assign ack_vec = ack_i ? (LINES'(1) << win_line_o) : '0;
  assign eoi_vec = eoi_i ? (LINES'(1) << eoi_line_i) : '0;
  assign pend    = irr_q & ~mask_i;

  always_comb begin
    p_hit = 1'b0;
    p_idx = '0;
    s_hit = 1'b0;
    s_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (pend[i]) begin
        p_hit = 1'b1;
        p_idx = LW'(i);
      end
      if (isr_q[i]) begin
        s_hit = 1'b1;
        s_idx = LW'(i);
      end
    end
  end

  assign win_o      = p_hit && (!s_hit || (p_idx < s_idx));
  assign win_line_o = p_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      irr_q  <= '0;
      isr_q  <= '0;
    end else begin
      last_q <= req_i;
      // acknowledge wins over an edge seen in the same cycle
      irr_q  <= (irr_q | rise) & ~ack_vec;
      isr_q  <= (isr_q | ack_vec) & ~eoi_vec;
    end
  end
endmodule

// File: rtl/pic_casc_link.sv
module pic_casc_link (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sec_win_i,
  input  logic hold_i,
  output logic pulse_o
);
  // pulse high one cycle, low the next; parked during acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= 1'b0;
    else         pulse_o <= sec_win_i & ~pulse_o & ~hold_i;
  end
endmodule

// File: rtl/pic_ack_seq.sv
module pic_ack_seq
  import pic_casc_pkg::*;
#(
  parameter  int unsigned LINES     = 8,
  parameter  int unsigned CASC_LINE = 2,
  parameter  int unsigned VEC_W     = 8,
  localparam int unsigned LW        = $clog2(LINES),
  localparam int unsigned BW        = VEC_W - LW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inta_i,
  input  logic             pri_win_i,
  input  logic [LW-1:0]    pri_line_i,
  input  logic             sec_win_i,
  input  logic [LW-1:0]    sec_line_i,
  input  logic [BW-1:0]    pri_base_i,
  input  logic [BW-1:0]    sec_base_i,
  output logic             pri_ack_o,
  output logic             sec_ack_o,
  output logic             vld_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [LW:0]      src_o
);
  localparam logic [LW-1:0] SPUR_L = LW'(LINES - 1);
  localparam logic [LW-1:0] CASC_L = LW'(CASC_LINE);

  ack_kind_e     kind;
  logic [LW-1:0] sel_line;
  logic [BW-1:0] sel_base;
  logic          from_sec;

  always_comb begin
    if (!pri_win_i)                kind = ACK_SPUR_PRI;
    else if (pri_line_i != CASC_L) kind = ACK_PRI;
    else if (sec_win_i)            kind = ACK_CASC;
    else                           kind = ACK_SPUR_SEC;
  end

  always_comb begin
    unique case (kind)
      ACK_PRI:      begin sel_line = pri_line_i; from_sec = 1'b0; end
      ACK_CASC:     begin sel_line = sec_line_i; from_sec = 1'b1; end
      ACK_SPUR_SEC: begin sel_line = SPUR_L;     from_sec = 1'b1; end
      default:      begin sel_line = SPUR_L;     from_sec = 1'b0; end
    endcase
    sel_base = from_sec ? sec_base_i : pri_base_i;
  end

  assign pri_ack_o = inta_i && pri_win_i;
  assign sec_ack_o = inta_i && (kind == ACK_CASC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      vec_o <= '0;
      src_o <= '0;
    end else begin
      vld_o <= inta_i;
      if (inta_i) begin
        vec_o <= {sel_base, sel_line};
        src_o <= {from_sec, sel_line};
      end
    end
  end
endmodule

// File: rtl/pic_casc_ack.sv
module pic_casc_ack #(
  parameter  int unsigned LINES     = 8,
  parameter  int unsigned CASC_LINE = 2,
  parameter  int unsigned VEC_W     = 8,
  localparam int unsigned LW        = $clog2(LINES),
  localparam int unsigned SRC_W     = LW + 1,
  localparam int unsigned N_SRC     = 2 * LINES,
  localparam int unsigned BW        = VEC_W - LW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic [N_SRC-1:0] mask_i,
  input  logic [VEC_W-1:0] pri_base_i,
  input  logic [VEC_W-1:0] sec_base_i,
  input  logic             inta_i,
  input  logic             eoi_i,
  input  logic [SRC_W-1:0] eoi_src_i,
  output logic             int_o,
  output logic             vec_vld_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [SRC_W-1:0] src_o
);
  logic [1:0][LINES-1:0] ctl_req;
  logic [1:0][LINES-1:0] ctl_mask;
  logic [1:0]            ctl_ack, ctl_eoi, ctl_win;
  logic [1:0][LW-1:0]    ctl_line;
  logic                  casc_pulse;
  logic                  pri_ack, sec_ack;
  logic [LW-1:0]         pri_line;
  logic                  unused_bits;

  assign unused_bits = ^{irq_i[CASC_LINE], pri_base_i[LW-1:0], sec_base_i[LW-1:0]};

  for (genvar b = 0; b < LINES; b++) begin : g_pri_req
    if (b == CASC_LINE) begin : g_casc
      assign ctl_req[0][b] = casc_pulse;
    end else begin : g_ext
      assign ctl_req[0][b] = irq_i[b];
    end
  end
  assign ctl_req[1] = irq_i[N_SRC-1:LINES];

  assign ctl_ack[0] = pri_ack;
  assign ctl_ack[1] = sec_ack;
  assign pri_line   = ctl_line[0];

  for (genvar c = 0; c < 2; c++) begin : g_ctl
    assign ctl_mask[c] = mask_i[c*LINES +: LINES];
    assign ctl_eoi[c]  = eoi_i && (eoi_src_i[LW] == 1'(c));

    pic_resolver #(.LINES(LINES)) u_res (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (ctl_req[c]),
      .mask_i     (ctl_mask[c]),
      .ack_i      (ctl_ack[c]),
      .eoi_i      (ctl_eoi[c]),
      .eoi_line_i (eoi_src_i[LW-1:0]),
      .win_o      (ctl_win[c]),
      .win_line_o (ctl_line[c])
    );
  end

  pic_casc_link u_link (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sec_win_i (ctl_win[1]),
    .hold_i    (inta_i),
    .pulse_o   (casc_pulse)
  );

  pic_ack_seq #(
    .LINES     (LINES),
    .CASC_LINE (CASC_LINE),
    .VEC_W     (VEC_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inta_i     (inta_i),
    .pri_win_i  (ctl_win[0]),
    .pri_line_i (ctl_line[0]),
    .sec_win_i  (ctl_win[1]),
    .sec_line_i (ctl_line[1]),
    .pri_base_i (pri_base_i[VEC_W-1:LW]),
    .sec_base_i (sec_base_i[VEC_W-1:LW]),
    .pri_ack_o  (pri_ack),
    .sec_ack_o  (sec_ack),
    .vld_o      (vec_vld_o),
    .vec_o      (vec_o),
    .src_o      (src_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) int_o <= 1'b0;
    else         int_o <= ctl_win[0];
  end
endmodule

// File: rtl/pic_casc_ack_chk.sv
module pic_casc_ack_chk #(
  parameter  int unsigned LINES     = 8,
  parameter  int unsigned CASC_LINE = 2,
  parameter  int unsigned VEC_W     = 8,
  localparam int unsigned LW        = $clog2(LINES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             inta_i,
  input logic [VEC_W-1:0] sec_base_i,
  input logic             vec_vld_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [LW:0]      src_o,
  input logic             casc_pulse,
  input logic             pri_ack,
  input logic             sec_ack,
  input logic [LW-1:0]    pri_line
);
  assert_vld_after_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i |=> vec_vld_o);
  assert_vld_only_after_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inta_i |=> !vec_vld_o);
  assert_casc_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_pulse |=> !casc_pulse);
  assert_sec_ack_via_casc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_ack |-> (pri_ack && pri_line == LW'(CASC_LINE)));
  assert_vec_low_is_line_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o |-> vec_o[LW-1:0] == src_o[LW-1:0]);
  assert_sec_base_used_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_vld_o && src_o[LW]) |-> vec_o[VEC_W-1:LW] == $past(sec_base_i[VEC_W-1:LW]));
endmodule

bind pic_casc_ack pic_casc_ack_chk #(
  .LINES     (LINES),
  .CASC_LINE (CASC_LINE),
  .VEC_W     (VEC_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .inta_i     (inta_i),
  .sec_base_i (sec_base_i),
  .vec_vld_o  (vec_vld_o),
  .vec_o      (vec_o),
  .src_o      (src_o),
  .casc_pulse (casc_pulse),
  .pri_ack    (pri_ack),
  .sec_ack    (sec_ack),
  .pri_line   (pri_line)
);

// File: tb/pic_casc_ack_bench.sv
module pic_casc_ack_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] irq_i = '0, mask_i = '0;
  logic [7:0]  pri_base_i = '0, sec_base_i = '0;
  logic        inta_i = 1'b0, eoi_i = 1'b0;
  logic [3:0]  eoi_src_i = '0;
  logic        int_o, vec_vld_o;
  logic [7:0]  vec_o;
  logic [3:0]  src_o;

  always #5 clk = ~clk;

  pic_casc_ack u_pic_casc_ack (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq_i), .mask_i(mask_i),
    .pri_base_i(pri_base_i), .sec_base_i(sec_base_i), .inta_i(inta_i),
    .eoi_i(eoi_i), .eoi_src_i(eoi_src_i), .int_o(int_o),
    .vec_vld_o(vec_vld_o), .vec_o(vec_o), .src_o(src_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0]  m_irr [2];
  logic [7:0]  m_isr [2];
  logic [15:0] m_last;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int low8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic int mwin(input int c);
    int p, s;
    p = low8(m_irr[c] & ~mask_i[c*8 +: 8]);
    s = low8(m_isr[c]);
    return (p < s) ? p : -1;
  endfunction

  task automatic settle();
    repeat (6) @(negedge clk);
    if (mwin(1) >= 0) m_irr[0][2] = 1'b1;
  endtask

  task automatic chk_int(input string req);
    int e;
    e = (mwin(0) >= 0) ? 1 : 0;
    chk(int'(int_o) == e, req, int'(int_o), e);
  endtask

  task automatic drive_irq(input logic [15:0] v, input string req);
    logic [15:0] rise;
    @(negedge clk);
    irq_i = v;
    rise = v & ~m_last;
    m_last = v;
    m_irr[0] = m_irr[0] | (rise[7:0] & 8'hFB);
    m_irr[1] = m_irr[1] | rise[15:8];
    settle();
    chk_int(req);
  endtask

  task automatic drive_mask(input logic [15:0] v, input string req);
    @(negedge clk);
    mask_i = v;
    settle();
    chk_int(req);
  endtask

  task automatic do_eoi(input int src, input string req);
    @(negedge clk);
    eoi_i = 1'b1;
    eoi_src_i = 4'(src);
    @(negedge clk);
    eoi_i = 1'b0;
    m_isr[src/8][src%8] = 1'b0;
    settle();
    chk_int(req);
  endtask

  task automatic do_ack(input string req);
    int p, s, es;
    logic [7:0] ev;
    @(negedge clk);
    p = mwin(0);
    s = mwin(1);
    if (p < 0) begin
      ev = {pri_base_i[7:3], 3'd7}; es = 7;
    end else if (p != 2) begin
      ev = {pri_base_i[7:3], 3'(p)}; es = p;
      m_irr[0][p] = 1'b0; m_isr[0][p] = 1'b1;
    end else begin
      m_irr[0][2] = 1'b0; m_isr[0][2] = 1'b1;
      if (s >= 0) begin
        ev = {sec_base_i[7:3], 3'(s)}; es = 8 + s;
        m_irr[1][s] = 1'b0; m_isr[1][s] = 1'b1;
      end else begin
        ev = {sec_base_i[7:3], 3'd7}; es = 15;
      end
    end
    inta_i = 1'b1;
    @(negedge clk);
    inta_i = 1'b0;
    chk(vec_vld_o == 1'b1, "R3", int'(vec_vld_o), 1);
    chk(vec_o == ev, req, int'(vec_o), int'(ev));
    chk(int'(src_o) == es, req, int'(src_o), es);
    @(negedge clk);
    chk(vec_vld_o == 1'b0, "R3", int'(vec_vld_o), 0);
    settle();
    chk_int("R12");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: act=%0d exp=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int op, c;
    logic [15:0] v;
    m_irr[0] = '0; m_irr[1] = '0; m_isr[0] = '0; m_isr[1] = '0; m_last = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(int_o == 1'b0, "R1", int'(int_o), 0);
    chk(vec_vld_o == 1'b0, "R1", int'(vec_vld_o), 0);
    chk(vec_o == 8'h00, "R1", int'(vec_o), 0);
    chk(src_o == 4'h0, "R1", int'(src_o), 0);

    // R7 spurious primary, R8 low base bits ignored
    pri_base_i = 8'h27; sec_base_i = 8'h75;
    do_ack("R7");
    chk(int_o == 1'b0, "R7", int'(int_o), 0);

    // R4 primary line 5
    drive_irq(16'h0020, "R4");
    do_ack("R4");
    // R10 held level: no second pending
    do_eoi(5, "R9");
    chk(int_o == 1'b0, "R10", int'(int_o), 0);
    do_ack("R10");
    drive_irq(16'h0000, "R10");
    drive_irq(16'h0020, "R10");
    chk(int_o == 1'b1, "R10", int'(int_o), 1);
    do_ack("R4");
    do_eoi(5, "R9");

    // R9 priority and in-service blocking
    drive_irq(16'h000A, "R9");
    do_ack("R9");
    do_ack("R9");
    do_eoi(1, "R9");
    do_ack("R9");
    do_eoi(3, "R9");
    drive_irq(16'h0000, "R9");

    // R2/R5 cascade through line 12
    drive_irq(16'h1000, "R2");
    chk(int_o == 1'b1, "R2", int'(int_o), 1);
    do_ack("R5");
    do_eoi(12, "R9");
    do_eoi(2, "R9");
    drive_irq(16'h0000, "R2");

    // R6 secondary winner withdrawn by mask after cascade
    drive_irq(16'h0200, "R2");
    drive_mask(16'h0200, "R11");
    chk(int_o == 1'b1, "R6", int'(int_o), 1);
    do_ack("R6");
    do_eoi(2, "R9");
    drive_mask(16'h0000, "R11");
    do_ack("R5");
    do_eoi(9, "R9");
    do_eoi(2, "R9");
    drive_irq(16'h0000, "R10");

    // R11 masked primary line
    drive_mask(16'h0010, "R11");
    drive_irq(16'h0010, "R11");
    chk(int_o == 1'b0, "R11", int'(int_o), 0);
    drive_mask(16'h0000, "R11");
    chk(int_o == 1'b1, "R11", int'(int_o), 1);
    do_ack("R4");
    do_eoi(4, "R9");

    // random phase
    for (int k = 0; k < 250; k++) begin
      op = $urandom % 7;
      case (op)
        0, 1: begin
          v = irq_i ^ (16'(1) << ($urandom % 16));
          if ($urandom % 4 == 0) v = v ^ 16'($urandom);
          drive_irq(v, "R10");
        end
        2, 3: do_ack("R5");
        4: begin
          if ((m_isr[0] | m_isr[1]) == 8'h00) do_ack("R7");
          else begin
            c = $urandom % 2;
            if (m_isr[c] == 8'h00) c = 1 - c;
            do_eoi(c * 8 + low8(m_isr[c]), "R9");
          end
        end
        5: drive_mask(($urandom % 3 == 0) ? 16'h0000 : 16'($urandom & $urandom & $urandom), "R11");
        default: begin
          @(negedge clk);
          pri_base_i = 8'($urandom);
          sec_base_i = 8'($urandom);
          do_ack("R8");
        end
      endcase
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule